// File: doc/BRIEF.md
# Ethernet Receive Queue Screener

This block assigns every received Ethernet frame to one of sixteen receive queues. Frame bytes arrive one per cycle on a simple byte stream that carries a valid qualifier and first-byte and last-byte markers. The block stores the leading bytes of each frame in a header buffer. Once the last byte has been taken, two banks of programmable screening rules are evaluated over that buffer. The winning queue number is then presented together with a single-cycle valid pulse.

The first bank matches on the UDP destination port and on the IPv4 traffic-class byte. The second bank matches on the EtherType and on up to three masked 16-bit compares. Those compares point into a shared table of mask, value and offset entries, and each entry picks its own base for the offset. Inside a rule, each condition is active only when its enable bit is set. A rule hits when at least one active condition agreed with the frame and no active condition disagreed. All rule words, the EtherType table and the compare table are static configuration inputs, and the integration layer keeps them stable while a frame is being classified.

Top module: `rx_queue_screener`

## Requirements
- R1: The header buffer holds the first HDR_BYTES (default 64) bytes of a frame, counted from the beat flagged as first byte. Bytes past that count are discarded. A first-byte beat always starts a new frame at byte 0, even when the previous frame never signalled a last byte.
- R2: The last-byte beat is accepted at clock edge k. `out_valid` is then high for exactly one cycle, after edge k+1. `out_queue` changes only together with `out_valid` and holds its value otherwise. Reset clears both to 0.
- R3: Bank-1 rule field layout. Queue in bits 3:0, traffic-class value in bits 11:4, UDP port value in bits 27:12, traffic-class enable in bit 28, UDP port enable in bit 29. The port condition compares frame bytes 36 (high) and 37 (low) with bits 27:12.
- R4: The bank-1 traffic-class condition compares frame byte 15 with bits 11:4.
- R5: A rule hits only when at least one enabled condition matched and no enabled condition mismatched. A rule with no enabled condition never hits.
- R6: Bank-1 rules are checked in ascending index order, then bank-2 rules in ascending index order. The first hit supplies the queue. When nothing hits, the queue is 0.
- R7: Bank-2 rule field layout. Queue in bits 3:0, EtherType table index in bits 11:9, EtherType enable in bit 12. The condition compares frame bytes 12 (high) and 13 (low) with the 16-bit table entry `etype_tab[16*i +: 16]`.
- R8: Bank-2 compare slots A, B and C each have a 5-bit table index at bits 17:13, 23:19 and 29:25, and an enable bit at 18, 24 and 30. Table entry k has word 0 at `cmp_tab[64*k +: 32]`, with the mask in bits 15:0 and the value in bits 31:16. Word 1 is at `cmp_tab[64*k+32 +: 32]`. The slot matches when (frame data AND mask) equals (value AND mask). The frame data is big-endian, taken from the byte at the offset and the byte after it.
- R9: Word 1 bits 6:0 hold a byte offset and bits 8:7 select its base: 0 means byte 0, 1 means byte 14, 2 means byte 34, 3 means byte 42.
- R10: A condition whose frame bytes lie past the captured length counts as a mismatch. This includes frames shorter than the field, and offsets beyond the captured header.
- R11: Frames may follow each other with no idle cycle. Each frame's result reflects only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte beat qualifier |
| in_sop | input | 1 | Beat is the first byte of a frame |
| in_eop | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| t1_rules | input | N_T1*32 | Bank-1 rule words, rule i at bits 32*i +: 32 |
| t2_rules | input | N_T2*32 | Bank-2 rule words, rule i at bits 32*i +: 32 |
| etype_tab | input | N_ET*16 | EtherType table, 16 bits per entry |
| cmp_tab | input | N_CMP*64 | Compare table, two 32-bit words per entry |
| out_valid | output | 1 | One-cycle pulse: classification ready |
| out_queue | output | 4 | Selected queue number |

## Verification
Two events can land in the same clock edge: a frame's result is registered, and the next frame's first byte overwrites the header buffer that result was computed from. The bench provokes this by sending two frames back to back with no idle beat. Each frame carries a different traffic-class byte that selects a different rule. The result pulse for the first frame is sampled in the middle of the second frame, and it must show the first frame's queue. The second frame's pulse must then show its own queue. A second overlap occurs when a new first-byte beat arrives in the middle of an unfinished frame. That case is judged by whether the queue reflects only the restarted frame.

// File: rtl/rxq_scr_pkg.sv
// Package: field positions of the screening rule words, frame byte
// positions used by the fixed conditions, and the offset-base decode.
// Assumes untagged Ethernet frames carrying IPv4 with a 20-byte header.
package rxq_scr_pkg;
    localparam int QW            = 4;

    // bank-1 rule word
    localparam int R1_TC_LSB     = 4;
    localparam int R1_PORT_LSB   = 12;
    localparam int R1_TC_EN      = 28;
    localparam int R1_PORT_EN    = 29;

    // bank-2 rule word
    localparam int R2_ET_LSB     = 9;
    localparam int R2_ET_W       = 3;
    localparam int R2_ET_EN      = 12;
    localparam int R2_CMP_LSB    = 13;
    localparam int R2_CMP_W      = 5;
    localparam int R2_CMP_STRIDE = 6;
    localparam int R2_SLOTS      = 3;

    // frame byte positions
    localparam int FR_ETYPE      = 12;
    localparam int FR_TCLASS     = 15;
    localparam int FR_UDP_DPORT  = 36;

    // offset bases
    localparam int BASE_L2_END   = 14;
    localparam int BASE_L3_END   = 34;
    localparam int UDP_HDR_LEN   = 8;

    // Decode the 2-bit offset-base select into a byte position.
    function automatic logic [8:0] base_of(input logic [1:0] sel);
        case (sel)
            2'd1:    base_of = 9'(BASE_L2_END);
            2'd2:    base_of = 9'(BASE_L3_END);
            2'd3:    base_of = 9'(BASE_L3_END + UDP_HDR_LEN);
            default: base_of = 9'd0;
        endcase
    endfunction
endpackage

// File: rtl/rxq_hdr_capture.sv
// Header capture: stores up to HDR_BYTES leading bytes of each frame.
// Reports the captured length and pulses frame_done for one cycle after
// the last-byte beat. Assumes in_sop marks byte 0. Bytes beyond the
// buffer only saturate the length.
module rxq_hdr_capture #(
    parameter int HDR_BYTES = 64,
    localparam int LENW     = $clog2(HDR_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic                   in_eop,
    input  logic [7:0]             in_data,
    output logic [HDR_BYTES*8-1:0] hdr,
    output logic [LENW-1:0]        hdr_len,
    output logic                   frame_done
);
    logic [LENW-1:0] wr_idx;

    // Write position: a first-byte beat restarts at 0.
    always_comb wr_idx = in_sop ? '0 : hdr_len;

    // Store bytes, track the captured length and flag the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr        <= '0;
            hdr_len    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= in_valid && in_eop;
            if (in_valid) begin
                if (wr_idx < LENW'(HDR_BYTES)) begin
                    hdr[int'(wr_idx)*8 +: 8] <= in_data;
                    hdr_len                  <= wr_idx + 1'b1;
                end else begin
                    hdr_len <= wr_idx;
                end
            end
        end
    end
endmodule

// File: rtl/rxq_t1_rule.sv
// Bank-1 rule evaluator: UDP destination port and IPv4 traffic-class
// conditions, each gated by its enable bit. Assumes HDR_BYTES covers
// byte 37. A field past the captured length counts as a mismatch.
module rxq_t1_rule
    import rxq_scr_pkg::*;
#(
    parameter int HDR_BYTES = 64,
    localparam int LENW     = $clog2(HDR_BYTES + 1)
) (
    input  logic [31:0]            rule,
    input  logic [HDR_BYTES*8-1:0] hdr,
    input  logic [LENW-1:0]        hdr_len,
    output logic                   hit
);
    logic [15:0] f_port;
    logic [7:0]  f_tc;
    logic        port_ok, tc_ok, matched, mism;
    logic        unused_bits;

    assign unused_bits = ^{rule[31:30], hdr};

    // Pick the frame fields and check they were captured.
    always_comb begin
        f_port  = {hdr[FR_UDP_DPORT*8 +: 8], hdr[(FR_UDP_DPORT+1)*8 +: 8]};
        f_tc    = hdr[FR_TCLASS*8 +: 8];
        port_ok = int'(hdr_len) >= FR_UDP_DPORT + 2;
        tc_ok   = int'(hdr_len) >= FR_TCLASS + 1;
    end

    // Fold the enabled conditions into matched / mismatched flags.
    always_comb begin
        matched = 1'b0;
        mism    = 1'b0;
        if (rule[R1_PORT_EN]) begin
            if (port_ok && f_port == rule[R1_PORT_LSB +: 16]) matched = 1'b1;
            else                                              mism    = 1'b1;
        end
        if (rule[R1_TC_EN]) begin
            if (tc_ok && f_tc == rule[R1_TC_LSB +: 8]) matched = 1'b1;
            else                                       mism    = 1'b1;
        end
        hit = matched && !mism;
    end
endmodule

// File: rtl/rxq_t2_rule.sv
// Bank-2 rule evaluator: EtherType condition plus three masked 16-bit
// compares that index a shared compare table. Table indices above the
// populated entries read as absent, and an absent entry mismatches.
// Compare data past the captured length also mismatches.
module rxq_t2_rule
    import rxq_scr_pkg::*;
#(
    parameter int HDR_BYTES = 64,
    parameter int N_ET      = 8,
    parameter int N_CMP     = 32,
    localparam int LENW     = $clog2(HDR_BYTES + 1),
    localparam int ET_SLOTS = 1 << R2_ET_W,
    localparam int CM_SLOTS = 1 << R2_CMP_W
) (
    input  logic [31:0]            rule,
    input  logic [HDR_BYTES*8-1:0] hdr,
    input  logic [LENW-1:0]        hdr_len,
    input  logic [N_ET*16-1:0]     etype_tab,
    input  logic [N_CMP*64-1:0]    cmp_tab,
    output logic                   hit
);
    logic [ET_SLOTS-1:0][15:0] et_pad;
    logic [ET_SLOTS-1:0]       et_ok;
    logic [CM_SLOTS-1:0][63:0] cm_pad;
    logic [CM_SLOTS-1:0]       cm_ok;
    logic [R2_SLOTS-1:0]       c_en, c_hit;
    logic [R2_ET_W-1:0]        et_idx;
    logic                      et_hit, matched, mism;
    logic                      unused_bits;

    assign unused_bits = ^{rule[31], rule[8:4]};

    // Pad the tables to the full index range; missing entries are absent.
    for (genvar e = 0; e < ET_SLOTS; e++) begin : g_et
        if (e < N_ET) begin : g_have
            assign et_pad[e] = etype_tab[16*e +: 16];
            assign et_ok[e]  = 1'b1;
        end else begin : g_none
            assign et_pad[e] = '0;
            assign et_ok[e]  = 1'b0;
        end
    end
    for (genvar k = 0; k < CM_SLOTS; k++) begin : g_cm
        if (k < N_CMP) begin : g_have
            assign cm_pad[k] = cmp_tab[64*k +: 64];
            assign cm_ok[k]  = 1'b1;
        end else begin : g_none
            assign cm_pad[k] = '0;
            assign cm_ok[k]  = 1'b0;
        end
    end

    // EtherType condition against the selected table entry.
    always_comb begin
        et_idx = rule[R2_ET_LSB +: R2_ET_W];
        et_hit = et_ok[et_idx] && (int'(hdr_len) >= FR_ETYPE + 2) &&
                 ({hdr[FR_ETYPE*8 +: 8], hdr[(FR_ETYPE+1)*8 +: 8]} == et_pad[et_idx]);
    end

    // One masked compare per slot, each with its own index and enable.
    for (genvar c = 0; c < R2_SLOTS; c++) begin : g_slot
        localparam int IDX_LSB = R2_CMP_LSB + R2_CMP_STRIDE*c;
        logic [R2_CMP_W-1:0] idx;
        logic [63:0]         ent;
        logic [8:0]          addr, rd_at;
        logic                avail;
        logic [15:0]         data;
        logic                unused_hi;

        assign c_en[c]   = rule[IDX_LSB + R2_CMP_W];
        assign unused_hi = ^ent[63:41];

        // Locate the frame data, read it and apply the mask.
        always_comb begin
            idx      = rule[IDX_LSB +: R2_CMP_W];
            ent      = cm_pad[idx];
            addr     = base_of(ent[40:39]) + {2'b00, ent[38:32]};
            avail    = cm_ok[idx] && (int'(addr) + 2 <= int'(hdr_len));
            rd_at    = avail ? addr : 9'd0;
            data     = {hdr[int'(rd_at)*8 +: 8], hdr[int'(rd_at)*8 + 8 +: 8]};
            c_hit[c] = avail && ((data & ent[15:0]) == (ent[31:16] & ent[15:0]));
        end
    end

    // Fold the enabled conditions into the rule result.
    always_comb begin
        matched = (rule[R2_ET_EN] && et_hit)  || |(c_en & c_hit);
        mism    = (rule[R2_ET_EN] && !et_hit) || |(c_en & ~c_hit);
        hit     = matched && !mism;
    end
endmodule

// File: rtl/rxq_queue_pick.sv
// Priority select: the lowest-index hit in bank 1 wins, then the
// lowest-index hit in bank 2. With no hit the queue is 0.
module rxq_queue_pick
    import rxq_scr_pkg::*;
#(
    parameter int N_T1 = 4,
    parameter int N_T2 = 4
) (
    input  logic [N_T1-1:0]    t1_hit,
    input  logic [N_T1*QW-1:0] t1_q,
    input  logic [N_T2-1:0]    t2_hit,
    input  logic [N_T2*QW-1:0] t2_q,
    output logic [QW-1:0]      q
);
    // Scan from the lowest priority upward so the best hit is written last.
    always_comb begin
        q = '0;
        for (int i = N_T2 - 1; i >= 0; i--)
            if (t2_hit[i]) q = t2_q[i*QW +: QW];
        for (int i = N_T1 - 1; i >= 0; i--)
            if (t1_hit[i]) q = t1_q[i*QW +: QW];
    end
endmodule

// File: rtl/rx_queue_screener.sv
// Top: captures each frame's header, evaluates both rule banks in one
// cycle after the frame ends, and registers the queue with a valid pulse.
// Assumes the configuration inputs are stable while a frame is classified.
module rx_queue_screener
    import rxq_scr_pkg::*;
#(
    parameter int N_T1      = 4,
    parameter int N_T2      = 4,
    parameter int N_ET      = 8,
    parameter int N_CMP     = 32,
    parameter int HDR_BYTES = 64,
    localparam int LENW     = $clog2(HDR_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [7:0]            in_data,
    input  logic [N_T1*32-1:0]    t1_rules,
    input  logic [N_T2*32-1:0]    t2_rules,
    input  logic [N_ET*16-1:0]    etype_tab,
    input  logic [N_CMP*64-1:0]   cmp_tab,
    output logic                  out_valid,
    output logic [QW-1:0]         out_queue
);
    logic [HDR_BYTES*8-1:0] hdr;
    logic [LENW-1:0]        hdr_len;
    logic                   frame_done;
    logic [N_T1-1:0]        t1_hit;
    logic [N_T2-1:0]        t2_hit;
    logic [N_T1*QW-1:0]     t1_q;
    logic [N_T2*QW-1:0]     t2_q;
    logic [QW-1:0]          pick_q;

    rxq_hdr_capture #(.HDR_BYTES(HDR_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .hdr(hdr), .hdr_len(hdr_len),
        .frame_done(frame_done)
    );

    for (genvar i = 0; i < N_T1; i++) begin : g_t1
        assign t1_q[i*QW +: QW] = t1_rules[32*i +: QW];
        rxq_t1_rule #(.HDR_BYTES(HDR_BYTES)) u_rule (
            .rule(t1_rules[32*i +: 32]), .hdr(hdr), .hdr_len(hdr_len),
            .hit(t1_hit[i])
        );
    end

    for (genvar i = 0; i < N_T2; i++) begin : g_t2
        assign t2_q[i*QW +: QW] = t2_rules[32*i +: QW];
        rxq_t2_rule #(.HDR_BYTES(HDR_BYTES), .N_ET(N_ET), .N_CMP(N_CMP)) u_rule (
            .rule(t2_rules[32*i +: 32]), .hdr(hdr), .hdr_len(hdr_len),
            .etype_tab(etype_tab), .cmp_tab(cmp_tab), .hit(t2_hit[i])
        );
    end

    rxq_queue_pick #(.N_T1(N_T1), .N_T2(N_T2)) u_pick (
        .t1_hit(t1_hit), .t1_q(t1_q), .t2_hit(t2_hit), .t2_q(t2_q), .q(pick_q)
    );

    // Register the chosen queue and raise the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_queue <= '0;
        end else begin
            out_valid <= frame_done;
            if (frame_done) out_queue <= pick_q;
        end
    end
endmodule

// File: rtl/rx_queue_screener_chk.sv
// Checker: port-level timing and default-queue properties of the screener.
module rx_queue_screener_chk #(
    parameter int N_T1 = 4,
    parameter int N_T2 = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_eop,
    input logic [N_T1*32-1:0] t1_rules,
    input logic [N_T2*32-1:0] t2_rules,
    input logic               out_valid,
    input logic [3:0]         out_queue
);
    logic any_en;

    // Any condition enable set in either bank.
    always_comb begin
        any_en = 1'b0;
        for (int i = 0; i < N_T1; i++)
            any_en |= t1_rules[32*i+28] | t1_rules[32*i+29];
        for (int i = 0; i < N_T2; i++)
            any_en |= t2_rules[32*i+12] | t2_rules[32*i+18] |
                      t2_rules[32*i+24] | t2_rules[32*i+30];
    end

    // R2: a result pulse comes only two edges after a last-byte beat.
    a_r2_valid_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_eop, 2));

    // R2: every last-byte beat produces a result pulse.
    a_r2_eop_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> ##1 out_valid);

    // R2: the queue output holds between results.
    a_r2_queue_held: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_queue));

    // R5/R6: with no enabled condition anywhere, the result is queue 0.
    a_r5_no_enable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(any_en)) |-> (out_queue == 4'd0));
endmodule

bind rx_queue_screener rx_queue_screener_chk #(.N_T1(N_T1), .N_T2(N_T2)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
    .t1_rules(t1_rules), .t2_rules(t2_rules),
    .out_valid(out_valid), .out_queue(out_queue)
);

// File: tb/rx_queue_screener_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the receive queue screener: one task per scenario.
module rx_queue_screener_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [3:0][31:0]  t1 = '0;
    logic [3:0][31:0]  t2 = '0;
    logic [7:0][15:0]  et = '0;
    logic [31:0][63:0] cmp = '0;
    logic out_valid;
    logic [3:0] out_queue;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] fr [0:127];

    always #2.5 clk = ~clk;

    rx_queue_screener dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .t1_rules(t1), .t2_rules(t2),
        .etype_tab(et), .cmp_tab(cmp), .out_valid(out_valid), .out_queue(out_queue)
    );

    function automatic logic [31:0] t1w(input logic [3:0] q, input logic [7:0] tc,
                                        input logic [15:0] port, input logic tc_en,
                                        input logic port_en);
        return {2'b00, port_en, tc_en, port, tc, q};
    endfunction

    function automatic logic [31:0] t2w(input logic [3:0] q, input logic [2:0] ei, input logic ee,
                                        input logic [4:0] ca, input logic cae,
                                        input logic [4:0] cb, input logic cbe,
                                        input logic [4:0] cc, input logic cce);
        return {1'b0, cce, cc, cbe, cb, cae, ca, ee, ei, 5'b00000, q};
    endfunction

    function automatic logic [63:0] cmpw(input logic [15:0] val, input logic [15:0] mask,
                                         input logic [1:0] sel, input logic [6:0] off);
        return {23'd0, sel, off, val, mask};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_cfg();
        t1 = '0; t2 = '0; et = '0; cmp = '0;
    endtask

    task automatic base_frame();
        for (int i = 0; i < 128; i++) fr[i] = 8'h00;
        fr[12] = 8'h08; fr[13] = 8'h00;
    endtask

    // Drive n bytes of fr, optionally flagging the last byte.
    task automatic drive(input int n, input bit with_eop);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (i == 0);
            in_eop = with_eop && (i == n - 1); in_data = fr[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // Send a frame and check the pulse timing, queue and hold (R2).
    task automatic run(input int n, input logic [3:0] exp, input string req);
        drive(n, 1'b1);
        chk(out_valid === 1'b0, "R2", "valid too early", out_valid, 0);
        @(negedge clk);
        chk(out_valid === 1'b1, "R2", "valid pulse", out_valid, 1);
        chk(out_queue === exp, req, "queue", out_queue, exp);
        @(negedge clk);
        chk(out_valid === 1'b0, "R2", "pulse one cycle", out_valid, 0);
        chk(out_queue === exp, "R2", "queue held", out_queue, exp);
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R2", "reset valid", out_valid, 0);
        chk(out_queue === 4'd0, "R2", "reset queue", out_queue, 0);
    endtask

    task automatic t_default();
        clear_cfg(); base_frame();
        run(64, 4'd0, "R6");
        t1[0] = t1w(4'd9, 8'h00, 16'h0000, 1'b0, 1'b0);    // R5: queue set, nothing enabled
        run(64, 4'd0, "R5");
    endtask

    task automatic t_udp_port();
        clear_cfg(); base_frame();
        t1[1] = t1w(4'd5, 8'h00, 16'h1234, 1'b0, 1'b1);
        fr[36] = 8'h12; fr[37] = 8'h34;
        run(64, 4'd5, "R3");
        fr[37] = 8'h35;
        run(64, 4'd0, "R3");
    endtask

    task automatic t_tclass();
        clear_cfg(); base_frame();
        t1[0] = t1w(4'd3, 8'hB8, 16'h0000, 1'b1, 1'b0);
        fr[15] = 8'hB8; run(64, 4'd3, "R4");
        fr[15] = 8'h10; run(64, 4'd0, "R4");
        t1[0] = t1w(4'd3, 8'hB8, 16'h1234, 1'b1, 1'b1);     // R5: both enabled
        fr[15] = 8'hB8; fr[36] = 8'h12; fr[37] = 8'h34;
        run(64, 4'd3, "R5");
        fr[37] = 8'h35;
        run(64, 4'd0, "R5");
    endtask

    task automatic t_priority();
        clear_cfg(); base_frame();
        fr[15] = 8'hB8;
        et[0] = 16'h0800;
        t1[2] = t1w(4'd7, 8'hB8, 16'h0, 1'b1, 1'b0);
        t1[3] = t1w(4'd9, 8'hB8, 16'h0, 1'b1, 1'b0);
        t2[0] = t2w(4'd11, 3'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        t2[1] = t2w(4'd1, 3'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        run(64, 4'd7, "R6");
        t1[2] = '0;
        run(64, 4'd9, "R6");
        t1[3] = '0;
        run(64, 4'd11, "R6");
    endtask

    task automatic t_etype();
        clear_cfg(); base_frame();
        et[3] = 16'h86DD;
        t2[1] = t2w(4'd6, 3'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        fr[12] = 8'h86; fr[13] = 8'hDD;
        run(64, 4'd6, "R7");
        fr[12] = 8'h08; fr[13] = 8'h00;
        run(64, 4'd0, "R7");
    endtask

    task automatic t_compare();
        clear_cfg(); base_frame();
        cmp[10] = cmpw(16'hAB00, 16'hFF00, 2'd0, 7'd20);
        t2[0] = t2w(4'd12, 3'd0, 1'b0, 5'd0, 1'b0, 5'd10, 1'b1, 5'd0, 1'b0);
        fr[20] = 8'hAB; fr[21] = 8'h55;
        run(64, 4'd12, "R8");
        fr[20] = 8'hAC;
        run(64, 4'd0, "R8");
        cmp[4] = cmpw(16'h0800, 16'hFFFF, 2'd0, 7'd12);
        cmp[5] = cmpw(16'h1111, 16'hFFFF, 2'd0, 7'd0);
        t2[0] = t2w(4'd12, 3'd0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 5'd5, 1'b1);
        run(64, 4'd0, "R8");                                 // slot C disagrees
        fr[0] = 8'h11; fr[1] = 8'h11;
        run(64, 4'd12, "R8");
    endtask

    task automatic t_offset_base();
        clear_cfg(); base_frame();
        t2[0] = t2w(4'd13, 3'd0, 1'b0, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        cmp[1] = cmpw(16'h5AA5, 16'hFFFF, 2'd1, 7'd2);
        fr[2] = 8'h5A; fr[3] = 8'hA5;
        run(64, 4'd0, "R9");
        fr[16] = 8'h5A; fr[17] = 8'hA5;
        run(64, 4'd13, "R9");
        cmp[1] = cmpw(16'h1234, 16'hFFFF, 2'd2, 7'd0);
        fr[34] = 8'h12; fr[35] = 8'h34;
        run(64, 4'd13, "R9");
        cmp[1] = cmpw(16'hCAFE, 16'hFFFF, 2'd3, 7'd1);
        fr[43] = 8'hCA; fr[44] = 8'hFE;
        run(64, 4'd13, "R9");
    endtask

    task automatic t_short();
        clear_cfg(); base_frame();
        t1[0] = t1w(4'd5, 8'h00, 16'h0000, 1'b0, 1'b1);
        run(37, 4'd0, "R10");
        run(38, 4'd5, "R10");
        clear_cfg();
        t2[0] = t2w(4'd2, 3'd0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        cmp[7] = cmpw(16'h0000, 16'h0000, 2'd0, 7'd63);
        run(64, 4'd0, "R10");
        cmp[7] = cmpw(16'h0000, 16'h0000, 2'd0, 7'd62);
        run(64, 4'd2, "R10");
    endtask

    task automatic t_long();
        clear_cfg(); base_frame();
        for (int i = 64; i < 100; i++) fr[i] = 8'hFF;
        t2[0] = t2w(4'd2, 3'd0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        cmp[7] = cmpw(16'h0000, 16'h0000, 2'd0, 7'd63);
        run(100, 4'd0, "R1");                                // byte 64 not captured
        cmp[7] = cmpw(16'h0000, 16'hFFFF, 2'd0, 7'd62);
        run(100, 4'd2, "R1");
    endtask

    task automatic t_restart();
        clear_cfg(); base_frame();
        t1[0] = t1w(4'd8, 8'h22, 16'h0, 1'b1, 1'b0);
        t1[1] = t1w(4'd9, 8'hB8, 16'h0, 1'b1, 1'b0);
        fr[15] = 8'hB8;
        drive(30, 1'b0);                                     // unfinished frame
        chk(out_valid === 1'b0, "R1", "no result without last byte", out_valid, 0);
        fr[15] = 8'h22;
        run(20, 4'd8, "R1");
    endtask

    task automatic t_back_to_back();
        logic [7:0] seq [0:39];
        clear_cfg();
        t1[0] = t1w(4'd3, 8'hB8, 16'h0, 1'b1, 1'b0);
        t1[1] = t1w(4'd4, 8'h10, 16'h0, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) seq[i] = 8'h00;
        seq[15] = 8'hB8; seq[35] = 8'h10;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i == 21) begin
                chk(out_valid === 1'b1, "R11", "first pulse", out_valid, 1);
                chk(out_queue === 4'd3, "R11", "first queue", out_queue, 3);
            end
            in_valid = 1'b1; in_sop = (i == 0 || i == 20);
            in_eop = (i == 19 || i == 39); in_data = seq[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b1, "R11", "second pulse", out_valid, 1);
        chk(out_queue === 4'd4, "R11", "second queue", out_queue, 4);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default();
        t_udp_port();
        t_tclass();
        t_priority();
        t_etype();
        t_compare();
        t_offset_base();
        t_short();
        t_long();
        t_restart();
        t_back_to_back();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule